// File: doc/BRIEF.md
# Direction-Steered Dual Byte Queue

This block holds two independent byte queues, each four entries deep, between a host bus and a datapath. A per-queue direction input decides which side produces and which side consumes. In input mode the host pushes bytes over the bus and the datapath pops them into a per-queue data register. In output mode the datapath pushes its accumulator byte and the host pops it over the bus. The direction of each queue is chosen on its own, so both-in, both-out and mixed setups all work.

The host bus is a single-cycle strobe: `host_valid_i` with `host_we_i`, an address, write data, and combinational read data that is valid in the same cycle as the strobe. A data read pops the queue at the clock edge that ends the strobe. Each queue drives level flags for empty, full and not-empty. It also drives a service request and sticky overflow and underflow flags, which can feed interrupts, DMA requests or a sequencer. A host read of a queue's status byte clears that queue's sticky flags. Any change of a queue's direction input flushes that queue.

Top module: `dfp_fifo_pair`

## Requirements
- R1: After reset both queues are empty, in input mode, with all flags clear and both data registers at 0x00. A pop of an empty queue before any successful pop returns 0x00.
- R2: In input mode (direction bit 0), a host write to address i pushes into queue i. A `dp_load_i[i]` pulse pops the oldest byte into data register i (`d_o` bits 8i+7..8i) at that clock edge, in first-in first-out order.
- R3: In output mode (direction bit 1), a `dp_store_i[i]` pulse pushes accumulator byte i (`acc_i` bits 8i+7..8i). A host read of address i returns the oldest byte combinationally and pops it at the edge.
- R4: Address i (i < 2) is queue i's data and address 2+i is its status byte. The status byte is bit0 empty, bit1 full, bit2 not-empty, bit3 overflow, bit4 underflow, bit5 direction, bit6 request, bit7 zero. `empty_o`, `full_o` and `not_empty_o` follow the occupancy.
- R5: `req_o[i]` is "space available" (not full) in input mode and "data available" (not empty) in output mode.
- R6: A push into a full queue with no pop in the same cycle is dropped and sets the sticky `ovf_o[i]`.
- R7: A pop of an empty queue returns the last successfully popped byte and sets the sticky `unf_o[i]`. In input mode the data register takes that same last byte.
- R8: A host read of status address 2+i clears both sticky flags of queue i from the next cycle on. The status byte returned shows them before clearing.
- R9: A push and a pop in the same cycle on a non-empty queue leave the occupancy unchanged. This holds when the queue is full, and raises no overflow.
- R10: A change of `dir_i[i]` empties queue i at the next edge. Pushes and pops on that queue in the same cycle are dropped.
- R11: Operations from the wrong side are ignored. In input mode `dp_store_i` has no effect, and a host data read returns 0x00 without popping. In output mode host writes and `dp_load_i` have no effect.
- R12: The two queues are independent: operations on one never change the flags or data of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dir_i | input | NUM_FIFO | Per-queue direction, 0 input mode, 1 output mode |
| host_valid_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | ADDR_W | Host address, data then status per queue |
| host_wdata_i | input | WIDTH | Host write data |
| host_rdata_o | output | WIDTH | Host read data, same cycle as the strobe |
| dp_load_i | input | NUM_FIFO | Datapath pop into data register |
| dp_store_i | input | NUM_FIFO | Datapath push of accumulator byte |
| acc_i | input | NUM_FIFO*WIDTH | Accumulator bytes, one per queue |
| d_o | output | NUM_FIFO*WIDTH | Data registers, one per queue |
| empty_o | output | NUM_FIFO | Queue empty |
| full_o | output | NUM_FIFO | Queue full |
| not_empty_o | output | NUM_FIFO | Queue holds at least one byte |
| req_o | output | NUM_FIFO | Space-available or data-available request |
| ovf_o | output | NUM_FIFO | Sticky overflow |
| unf_o | output | NUM_FIFO | Sticky underflow |

## Verification
The bench pushes past the fourth byte and checks that the fifth is lost. A design that overwrote the oldest entry would hand back the wrong first byte, and one that wrapped the count would report empty. It pops empty queues in both modes, where a wrong design returns a stale slot, zero, or a data register that changed. It drives a push and a pop in the same cycle at partial, full and empty occupancy, where a wrong design miscounts, overflows or drops the incoming byte. It also flips directions with traffic in the same cycle and checks that a design without a flush keeps old bytes or accepts the dropped operation, and that wrong-side strobes leave both queues and data registers untouched.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  // status byte bits 6..0, bit 7 reads zero
  typedef struct packed {
    logic req;
    logic dir;
    logic unf;
    logic ovf;
    logic not_empty;
    logic full;
    logic empty;
  } fifo_stat_t;

  localparam int unsigned STAT_W = $bits(fifo_stat_t);
endpackage

// File: rtl/dfp_fifo_core.sv
module dfp_fifo_core #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clr_sticky_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] last_q;
  logic             ovf_q, unf_q;
  logic             push_ok, pop_ok, ovf_set, unf_set;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign rdata_o = empty_o ? last_q : mem_q[rd_ptr_q];

  // a pop in the same cycle frees the slot a full push needs
  assign push_ok = push_i && !flush_i && (!full_o || pop_i);
  assign pop_ok  = pop_i && !flush_i && !empty_o;
  assign ovf_set = push_i && !flush_i && full_o && !pop_i;
  assign unf_set = pop_i && !flush_i && empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (push_ok) begin
      mem_q[wr_ptr_q] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
    end else if (pop_ok) begin
      last_q <= mem_q[rd_ptr_q];
    end
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (ovf_set)           ovf_q <= 1'b1;
      else if (clr_sticky_i) ovf_q <= 1'b0;
      if (unf_set)           unf_q <= 1'b1;
      else if (clr_sticky_i) unf_q <= 1'b0;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  // R6
  ovf_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && ovf_o);

  // R7
  unf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !flush_i |=> unf_o && $stable(last_q));

  // R9
  simul_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !empty_o && !flush_i |=> $stable(cnt_q));

  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_sticky_i |=> ovf_o);
endmodule

// File: rtl/dfp_lane.sv
module dfp_lane
  import dfp_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             host_wr_i,
  input  logic             host_rd_i,
  input  logic             stat_rd_i,
  input  logic [WIDTH-1:0] host_wdata_i,
  input  logic             dp_load_i,
  input  logic             dp_store_i,
  input  logic [WIDTH-1:0] acc_i,
  output logic [WIDTH-1:0] d_o,
  output logic [WIDTH-1:0] host_rdata_o,
  output fifo_stat_t       stat_o
);
  logic             dir_q, dir_chg;
  logic             push, pop;
  logic [WIDTH-1:0] wdata, rdata;
  logic             empty, full, ovf, unf;
  logic [WIDTH-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else         dir_q <= dir_i;
  end

  assign dir_chg = dir_i ^ dir_q;

  // producer/consumer swap with the direction bit
  assign push  = dir_q ? dp_store_i : host_wr_i;
  assign wdata = dir_q ? acc_i      : host_wdata_i;
  assign pop   = dir_q ? host_rd_i  : dp_load_i;

  dfp_fifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (dir_chg),
    .push_i      (push),
    .pop_i       (pop),
    .clr_sticky_i(stat_rd_i),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .empty_o     (empty),
    .full_o      (full),
    .ovf_o       (ovf),
    .unf_o       (unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else if (!dir_q && !dir_chg && dp_load_i) d_q <= rdata;
  end

  assign d_o          = d_q;
  assign host_rdata_o = dir_q ? rdata : '0;

  always_comb begin
    stat_o.empty     = empty;
    stat_o.full      = full;
    stat_o.not_empty = !empty;
    stat_o.ovf       = ovf;
    stat_o.unf       = unf;
    stat_o.dir       = dir_q;
    stat_o.req       = dir_q ? !empty : !full;
  end

  // R11
  ign_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_q && dp_load_i |=> $stable(d_q));

  // R11
  ign_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_q && !dir_chg && empty && dp_store_i && !host_wr_i |=> empty);
endmodule

// File: rtl/dfp_host_if.sv
module dfp_host_if #(
  parameter int unsigned NUM_FIFO = 2,
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                             host_valid_i,
  input  logic                             host_we_i,
  input  logic [ADDR_W-1:0]                host_addr_i,
  input  logic [NUM_FIFO-1:0][WIDTH-1:0]   data_rd_i,
  input  logic [NUM_FIFO-1:0][WIDTH-1:0]   stat_i,
  output logic [NUM_FIFO-1:0]              wr_o,
  output logic [NUM_FIFO-1:0]              rd_o,
  output logic [NUM_FIFO-1:0]              stat_rd_o,
  output logic [WIDTH-1:0]                 rdata_o
);
  logic rd_acc;
  assign rd_acc = host_valid_i && !host_we_i;

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_dec
    assign wr_o[i]      = host_valid_i && host_we_i && (host_addr_i == ADDR_W'(i));
    assign rd_o[i]      = rd_acc && (host_addr_i == ADDR_W'(i));
    assign stat_rd_o[i] = rd_acc && (host_addr_i == ADDR_W'(NUM_FIFO + i));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FIFO; i++) begin
      if (rd_o[i])      rdata_o = data_rd_i[i];
      if (stat_rd_o[i]) rdata_o = stat_i[i];
    end
  end

  // R4
  one_target_chk: assert final ($onehot0({wr_o, rd_o, stat_rd_o}));
endmodule

// File: rtl/dfp_fifo_pair.sv
module dfp_fifo_pair
  import dfp_pkg::*;
#(
  parameter int unsigned NUM_FIFO = 2,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned WIDTH    = 8,
  localparam int unsigned ADDR_W  = $clog2(2 * NUM_FIFO)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_FIFO-1:0]       dir_i,
  input  logic                      host_valid_i,
  input  logic                      host_we_i,
  input  logic [ADDR_W-1:0]         host_addr_i,
  input  logic [WIDTH-1:0]          host_wdata_i,
  output logic [WIDTH-1:0]          host_rdata_o,
  input  logic [NUM_FIFO-1:0]       dp_load_i,
  input  logic [NUM_FIFO-1:0]       dp_store_i,
  input  logic [NUM_FIFO*WIDTH-1:0] acc_i,
  output logic [NUM_FIFO*WIDTH-1:0] d_o,
  output logic [NUM_FIFO-1:0]       empty_o,
  output logic [NUM_FIFO-1:0]       full_o,
  output logic [NUM_FIFO-1:0]       not_empty_o,
  output logic [NUM_FIFO-1:0]       req_o,
  output logic [NUM_FIFO-1:0]       ovf_o,
  output logic [NUM_FIFO-1:0]       unf_o
);
  logic [NUM_FIFO-1:0]            wr, rd, stat_rd;
  logic [NUM_FIFO-1:0][WIDTH-1:0] data_rd, stat_byte;
  fifo_stat_t                     stat [NUM_FIFO];

  dfp_host_if #(.NUM_FIFO(NUM_FIFO), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_host (
    .host_valid_i(host_valid_i),
    .host_we_i   (host_we_i),
    .host_addr_i (host_addr_i),
    .data_rd_i   (data_rd),
    .stat_i      (stat_byte),
    .wr_o        (wr),
    .rd_o        (rd),
    .stat_rd_o   (stat_rd),
    .rdata_o     (host_rdata_o)
  );

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_lane
    dfp_lane #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dir_i       (dir_i[i]),
      .host_wr_i   (wr[i]),
      .host_rd_i   (rd[i]),
      .stat_rd_i   (stat_rd[i]),
      .host_wdata_i(host_wdata_i),
      .dp_load_i   (dp_load_i[i]),
      .dp_store_i  (dp_store_i[i]),
      .acc_i       (acc_i[i*WIDTH +: WIDTH]),
      .d_o         (d_o[i*WIDTH +: WIDTH]),
      .host_rdata_o(data_rd[i]),
      .stat_o      (stat[i])
    );

    assign stat_byte[i]   = WIDTH'(stat[i]);
    assign empty_o[i]     = stat[i].empty;
    assign full_o[i]      = stat[i].full;
    assign not_empty_o[i] = stat[i].not_empty;
    assign req_o[i]       = stat[i].req;
    assign ovf_o[i]       = stat[i].ovf;
    assign unf_o[i]       = stat[i].unf;
  end
endmodule

// File: tb/dfp_fifo_pair_tb.sv
`timescale 1ns/1ps
module dfp_fifo_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dir = '0;
  logic        hv = 1'b0, hwe = 1'b0;
  logic [1:0]  haddr = '0;
  logic [7:0]  hwd = '0;
  logic [7:0]  hrd;
  logic [1:0]  ld = '0, st = '0;
  logic [15:0] acc = '0;
  logic [15:0] d;
  logic [1:0]  empty, full, nempty, req, ovf, unf;
  int checks = 0, fails = 0;
  logic [7:0] r;

  always #2.5 clk = ~clk;

  dfp_fifo_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir),
    .host_valid_i(hv), .host_we_i(hwe), .host_addr_i(haddr),
    .host_wdata_i(hwd), .host_rdata_o(hrd),
    .dp_load_i(ld), .dp_store_i(st), .acc_i(acc), .d_o(d),
    .empty_o(empty), .full_o(full), .not_empty_o(nempty),
    .req_o(req), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // one bus/datapath cycle; outputs of registers are sampled at the following negedge
  task automatic step(logic v, logic we, logic [1:0] a, logic [7:0] wd,
                      logic [1:0] l, logic [1:0] s, logic [15:0] ac,
                      output logic [7:0] rd);
    @(negedge clk);
    hv = v; hwe = we; haddr = a; hwd = wd; ld = l; st = s; acc = ac;
    #1 rd = hrd;
    @(negedge clk);
    hv = 0; hwe = 0; ld = '0; st = '0;
  endtask

  task automatic bwr(logic [1:0] a, logic [7:0] v);
    logic [7:0] x;
    step(1, 1, a, v, 2'b00, 2'b00, 16'h0, x);
  endtask

  task automatic brd(logic [1:0] a, output logic [7:0] v);
    step(1, 0, a, 8'h0, 2'b00, 2'b00, 16'h0, v);
  endtask

  task automatic dpop(logic [1:0] l);
    logic [7:0] x;
    step(0, 0, 2'd0, 8'h0, l, 2'b00, 16'h0, x);
  endtask

  task automatic dpush(logic [1:0] s, logic [15:0] ac);
    logic [7:0] x;
    step(0, 0, 2'd0, 8'h0, 2'b00, s, ac, x);
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 2'b11);
    chk("R1 full", full, 2'b00);
    chk("R1 sticky", {ovf, unf}, 4'b0);
    chk("R1 data regs", d, 16'h0);
    chk("R5 req input", req, 2'b11);
    brd(2'd2, r);
    chk("R4 status reset", r, 8'h41);
  endtask

  task automatic t_input();
    bwr(2'd0, 8'h11); bwr(2'd0, 8'h22); bwr(2'd0, 8'h33);
    chk("R4 not_empty", {nempty[0], empty[0], full[0]}, 3'b100);
    brd(2'd2, r);
    chk("R4 status partial", r, 8'h44);
    bwr(2'd0, 8'h44);
    chk("R4 full", full[0], 1'b1);
    chk("R5 req full", req[0], 1'b0);
    bwr(2'd0, 8'h55);
    chk("R6 ovf set", ovf[0], 1'b1);
    brd(2'd2, r);
    chk("R8 status shows ovf", r, 8'h0E);
    chk("R8 ovf cleared", ovf[0], 1'b0);
    dpop(2'b01); chk("R2 pop1", d[7:0], 8'h11);
    dpop(2'b01); chk("R2 pop2", d[7:0], 8'h22);
    dpop(2'b01); chk("R2 pop3", d[7:0], 8'h33);
    dpop(2'b01); chk("R6 dropped, pop4", d[7:0], 8'h44);
    chk("R2 empty", empty[0], 1'b1);
    chk("R12 other untouched", {empty[1], nempty[1], d[15:8]}, 10'b10_0000_0000);
    dpop(2'b01);
    chk("R7 unf set", unf[0], 1'b1);
    chk("R7 data reg last", d[7:0], 8'h44);
    brd(2'd2, r);
    chk("R8 status unf", r, 8'h51);
    chk("R8 unf cleared", unf[0], 1'b0);
  endtask

  task automatic t_output();
    @(negedge clk); dir = 2'b10;
    @(negedge clk);
    brd(2'd3, r);
    chk("R4 status output empty", r, 8'h21);
    chk("R5 req output empty", req[1], 1'b0);
    brd(2'd1, r);
    chk("R1 first underflow 0x00", r, 8'h00);
    chk("R7 unf out", unf[1], 1'b1);
    brd(2'd3, r);
    chk("R8 status out unf", r, 8'h31);
    dpush(2'b10, 16'hA100);
    dpush(2'b10, 16'hA200);
    chk("R5 req data avail", req[1], 1'b1);
    chk("R12 F0 untouched", {empty[0], nempty[0]}, 2'b10);
    brd(2'd1, r); chk("R3 read1", r, 8'hA1);
    brd(2'd1, r); chk("R3 read2", r, 8'hA2);
    chk("R3 empty", empty[1], 1'b1);
    brd(2'd1, r);
    chk("R7 last value", r, 8'hA2);
    chk("R7 unf", unf[1], 1'b1);
    brd(2'd3, r);
  endtask

  task automatic t_ignore();
    dpop(2'b10);
    chk("R11 load ignored in output", d[15:8], 8'h00);
    bwr(2'd1, 8'h99);
    chk("R11 host write ignored in output", empty[1], 1'b1);
    dpush(2'b01, 16'h005A);
    chk("R11 store ignored in input", empty[0], 1'b1);
    bwr(2'd0, 8'h66);
    brd(2'd0, r);
    chk("R11 host data read in input", r, 8'h00);
    chk("R11 no pop", nempty[0], 1'b1);
    dpop(2'b01);
    chk("R11 byte kept", d[7:0], 8'h66);
  endtask

  task automatic t_simul();
    bwr(2'd0, 8'h10); bwr(2'd0, 8'h20);
    step(1, 1, 2'd0, 8'h30, 2'b01, 2'b00, 16'h0, r);
    chk("R9 simul pop", d[7:0], 8'h10);
    bwr(2'd0, 8'h40);
    chk("R9 count kept", full[0], 1'b0);
    bwr(2'd0, 8'h50);
    chk("R9 full at 4", full[0], 1'b1);
    step(1, 1, 2'd0, 8'h60, 2'b01, 2'b00, 16'h0, r);
    chk("R9 full simul", {full[0], ovf[0]}, 2'b10);
    chk("R9 full simul data", d[7:0], 8'h20);
    dpop(2'b01); chk("R9 order a", d[7:0], 8'h30);
    dpop(2'b01); chk("R9 order b", d[7:0], 8'h40);
    dpop(2'b01); chk("R9 order c", d[7:0], 8'h50);
    dpop(2'b01); chk("R9 order d", d[7:0], 8'h60);
    step(1, 1, 2'd0, 8'h70, 2'b01, 2'b00, 16'h0, r);
    chk("R9 empty simul", {unf[0], nempty[0]}, 2'b11);
    chk("R7 empty simul data", d[7:0], 8'h60);
    dpop(2'b01); chk("R9 empty simul kept", d[7:0], 8'h70);
    brd(2'd2, r);
  endtask

  task automatic t_flush();
    bwr(2'd0, 8'h01); bwr(2'd0, 8'h02);
    @(negedge clk); dir[0] = 1'b1; st = 2'b01; acc = 16'h00EE;
    @(negedge clk); st = '0;
    chk("R10 flushed", empty[0], 1'b1);
    chk("R10 store dropped", nempty[0], 1'b0);
    @(negedge clk); dir[0] = 1'b0; hv = 1; hwe = 1; haddr = 2'd0; hwd = 8'h03;
    @(negedge clk); hv = 0; hwe = 0;
    chk("R10 write dropped", empty[0], 1'b1);
    chk("R12 F1 untouched", {dir[1], empty[1]}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_input();
    t_output();
    t_ignore();
    t_simul();
    t_flush();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule